// File: doc/BRIEF.md
# Interleaved Multi-Context Issue Scheduler

This block decides, on every clock, which emulated processor context issues its next instruction into a shared execution pipeline. The slot pointer walks through the contexts in a fixed circular order and advances every cycle. A context therefore never occupies two adjacent pipeline stages. As long as the context count is at least the pipeline depth, one context's instructions are never in flight at the same time, and the pipeline needs no forwarding paths and no interlocks.

The scheduler stores a program counter and a status for every context. When the pipeline finds that an instruction has to wait for a memory access or for a hand-off to the slow software model, it reports a block. The context then gives up its turn, and a bubble goes out in its slot. The other contexts keep issuing in their own slots, which hides the wait. When the wait ends, a completion carrying the resume PC makes the context eligible again. Each issue carries the context id with it, so that writeback reaches the right register bank.

Top module: `ctx_interleave_sched`

## Requirements
- R1: `issueCtx` is the slot pointer. It is 0 after reset and goes up by one every cycle, wrapping from CONTEXTS-1 to 0, whatever state the contexts are in.
- R2: A context issues at most once per rotation. Two issues of the same context are at least CONTEXTS cycles apart, which is never fewer than STAGES cycles. A setting with CONTEXTS < STAGES fails at elaboration.
- R3: When the context in the current slot is not ready, `issueValid` is 0 for that cycle. The slot is not handed to another context.
- R4: A block (`blkValid`) on a ready context puts it into a waiting state from the next cycle: memory wait when `blkKind`=0, transplant wait when `blkKind`=1. A block on the context in the current slot does not cancel that cycle's issue.
- R5: A completion (`cmpValid`) whose source matches the wait kind (`cmpSrc`=0 for memory, 1 for transplant) makes the context ready on the next cycle, with its PC set to `cmpPc`.
- R6: A completion is ignored, with no change to PC or state, when its source does not match the wait kind or when the target context is already ready.
- R7: When a context issues, `issuePc` is that context's PC. Its stored PC then advances by PC_STEP.
- R8: Reset makes every context ready with PC RESET_PC and puts the slot pointer at context 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| blkValid | input | 1 | Block request for a context |
| blkCtx | input | CTX_W | Context to block |
| blkKind | input | 1 | Wait kind: 0 memory, 1 transplant |
| cmpValid | input | 1 | Completion returning a context |
| cmpCtx | input | CTX_W | Context being completed |
| cmpSrc | input | 1 | Completion source: 0 memory, 1 transplant |
| cmpPc | input | PC_W | PC at which the context resumes |
| issueValid | output | 1 | An instruction is issued this cycle |
| issueCtx | output | CTX_W | Context owning the current slot |
| issuePc | output | PC_W | PC of the issued instruction |

## Verification
The bench sends a memory completion to a context that is waiting on a transplant. A design that ignores the source wakes the context early, and the context then shows the wrong resume PC. The bench also sends a completion to a context that is still ready. A design that accepts it overwrites the running PC, and the jump shows up in that context's next issue. In one cycle the bench both blocks a ready context and sends it a completion. A design with the wrong priority issues in the slot where a bubble is due. The bench also blocks the context that holds the current slot, and runs a reset partway through. A design that reorders slots, cancels the current issue or loses the PC stepping fails on slot id, valid or PC.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    CTX_READY    = 2'd0,
    CTX_WAIT_MEM = 2'd1,
    CTX_WAIT_XPL = 2'd2
  } ctxState_e;

  typedef struct packed {
    logic fire;   // current slot issues; step its PC
    logic load;   // completion accepted; load resume PC
  } pcStrobe_t;
endpackage

// File: rtl/ctx_sched_ctrl.sv
module ctx_sched_ctrl
  import sched_pkg::*;
#(
  parameter int CONTEXTS = 8,
  parameter int STAGES   = 4,
  localparam int CTX_W   = (CONTEXTS > 1) ? $clog2(CONTEXTS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             blkValid,
  input  logic [CTX_W-1:0] blkCtx,
  input  logic             blkKind,
  input  logic             cmpValid,
  input  logic [CTX_W-1:0] cmpCtx,
  input  logic             cmpSrc,
  output logic [CTX_W-1:0] slotCtx,
  output logic             slotReady,
  output pcStrobe_t        strobe,
  output logic [CTX_W-1:0] loadCtx
);
  localparam logic [CTX_W-1:0] LAST = CTX_W'(CONTEXTS - 1);

  // R2: no hazard logic exists, so a shallow rotation is refused outright
  if (CONTEXTS < STAGES) begin : g_badCfg
    $error("ctx_sched_ctrl: CONTEXTS must be >= STAGES");
  end

  logic [CTX_W-1:0]            slotQ;
  ctxState_e [CONTEXTS-1:0]    stateQ;
  ctxState_e                   cmpWant;
  logic                        blkInRange, cmpInRange;
  logic                        wakeHit, blockHit;

  // rotation pointer: advances every cycle, never skips
  always_ff @(posedge clk) begin
    if (!rstN)               slotQ <= '0;
    else if (slotQ == LAST)  slotQ <= '0;
    else                     slotQ <= slotQ + 1'b1;
  end

  always_comb begin
    blkInRange = 32'(blkCtx) < CONTEXTS;
    cmpInRange = 32'(cmpCtx) < CONTEXTS;
    cmpWant    = cmpSrc ? CTX_WAIT_XPL : CTX_WAIT_MEM;
    wakeHit    = cmpValid && cmpInRange && (stateQ[cmpCtx] == cmpWant);
    blockHit   = blkValid && blkInRange && (stateQ[blkCtx] == CTX_READY);
  end

  // wake needs a waiting context and block needs a ready one: never both
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CONTEXTS; i++) stateQ[i] <= CTX_READY;
    end else begin
      for (int i = 0; i < CONTEXTS; i++) begin
        if (wakeHit && cmpCtx == CTX_W'(i))
          stateQ[i] <= CTX_READY;
        else if (blockHit && blkCtx == CTX_W'(i))
          stateQ[i] <= blkKind ? CTX_WAIT_XPL : CTX_WAIT_MEM;
      end
    end
  end

  always_comb begin
    slotCtx     = slotQ;
    slotReady   = (stateQ[slotQ] == CTX_READY);
    strobe.fire = slotReady;
    strobe.load = wakeHit;
    loadCtx     = cmpCtx;
  end

  a_r1_rotate: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> slotQ == (($past(slotQ) == LAST) ? '0 : $past(slotQ) + 1'b1));

  a_r4_block: assert property (@(posedge clk) disable iff (!rstN)
    (blkValid && blkInRange && stateQ[blkCtx] == CTX_READY)
      |=> stateQ[$past(blkCtx)] != CTX_READY);

  a_r5_wake: assert property (@(posedge clk) disable iff (!rstN)
    (cmpValid && cmpInRange && stateQ[cmpCtx] == cmpWant)
      |=> stateQ[$past(cmpCtx)] == CTX_READY);

  a_r6_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (cmpValid && cmpInRange && stateQ[cmpCtx] != CTX_READY && stateQ[cmpCtx] != cmpWant)
      |=> stateQ[$past(cmpCtx)] == $past(stateQ[cmpCtx]));
endmodule

// File: rtl/ctx_pc_store.sv
module ctx_pc_store
  import sched_pkg::*;
#(
  parameter int CONTEXTS = 8,
  parameter int PC_W     = 32,
  parameter int PC_STEP  = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int CTX_W   = (CONTEXTS > 1) ? $clog2(CONTEXTS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  pcStrobe_t        strobe,
  input  logic [CTX_W-1:0] fireCtx,
  input  logic [CTX_W-1:0] loadCtx,
  input  logic [PC_W-1:0]  loadPc,
  output logic [PC_W-1:0]  firePc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  logic [CONTEXTS-1:0][PC_W-1:0] pcQ;
  logic                          sameCtx;

  assign sameCtx = strobe.load && (loadCtx == fireCtx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CONTEXTS; i++) pcQ[i] <= RESET_PC;
    end else begin
      if (strobe.load)             pcQ[loadCtx] <= loadPc;
      if (strobe.fire && !sameCtx) pcQ[fireCtx] <= pcQ[fireCtx] + STEP;
    end
  end

  assign firePc = pcQ[fireCtx];

  a_r7_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && !sameCtx) |=> pcQ[$past(fireCtx)] == $past(pcQ[fireCtx]) + STEP);

  a_r5_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> pcQ[$past(loadCtx)] == $past(loadPc));
endmodule

// File: rtl/ctx_interleave_sched.sv
module ctx_interleave_sched
  import sched_pkg::*;
#(
  parameter int CONTEXTS = 8,
  parameter int STAGES   = 4,
  parameter int PC_W     = 32,
  parameter int PC_STEP  = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int CTX_W   = (CONTEXTS > 1) ? $clog2(CONTEXTS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             blkValid,
  input  logic [CTX_W-1:0] blkCtx,
  input  logic             blkKind,
  input  logic             cmpValid,
  input  logic [CTX_W-1:0] cmpCtx,
  input  logic             cmpSrc,
  input  logic [PC_W-1:0]  cmpPc,
  output logic             issueValid,
  output logic [CTX_W-1:0] issueCtx,
  output logic [PC_W-1:0]  issuePc
);
  pcStrobe_t        strobe;
  logic [CTX_W-1:0] slotCtx;
  logic [CTX_W-1:0] loadCtx;
  logic             slotReady;

  ctx_sched_ctrl #(.CONTEXTS(CONTEXTS), .STAGES(STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .blkValid(blkValid), .blkCtx(blkCtx), .blkKind(blkKind),
    .cmpValid(cmpValid), .cmpCtx(cmpCtx), .cmpSrc(cmpSrc),
    .slotCtx(slotCtx), .slotReady(slotReady), .strobe(strobe), .loadCtx(loadCtx)
  );

  ctx_pc_store #(.CONTEXTS(CONTEXTS), .PC_W(PC_W), .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)) u_pcs (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .fireCtx(slotCtx), .loadCtx(loadCtx), .loadPc(cmpPc), .firePc(issuePc)
  );

  assign issueValid = slotReady;
  assign issueCtx   = slotCtx;
endmodule

// File: tb/ctx_interleave_sched_bench.sv
`timescale 1ns/1ps
module ctx_interleave_sched_bench;
  localparam int NCTX = 4;
  localparam int NSTG = 4;
  localparam int NROW = 21;

  typedef struct packed {
    logic        blk;  logic [1:0] bCtx; logic bKind;
    logic        cmp;  logic [1:0] cCtx; logic cSrc; logic [15:0] cPc;
    logic        eV;   logic [1:0] eCtx; logic [15:0] ePc;
  } vec_t;

  // per cycle after reset: stimulus applied at the next edge, expected outputs this cycle
  localparam vec_t VECS [NROW] = '{
    '{1'b1,2'd1,1'b0, 1'b0,2'd0,1'b0,16'h000, 1'b1,2'd0,16'h100},
    '{1'b0,2'd0,1'b0, 1'b0,2'd0,1'b0,16'h000, 1'b0,2'd1,16'h000},
    '{1'b1,2'd3,1'b1, 1'b0,2'd0,1'b0,16'h000, 1'b1,2'd2,16'h100},
    '{1'b0,2'd0,1'b0, 1'b1,2'd1,1'b1,16'h280, 1'b0,2'd3,16'h000},
    '{1'b0,2'd0,1'b0, 1'b1,2'd1,1'b0,16'h200, 1'b1,2'd0,16'h104},
    '{1'b0,2'd0,1'b0, 1'b1,2'd2,1'b0,16'h300, 1'b1,2'd1,16'h200},
    '{1'b0,2'd0,1'b0, 1'b1,2'd3,1'b1,16'h400, 1'b1,2'd2,16'h104},
    '{1'b1,2'd0,1'b1, 1'b0,2'd0,1'b0,16'h000, 1'b1,2'd3,16'h400},
    '{1'b0,2'd0,1'b0, 1'b0,2'd0,1'b0,16'h000, 1'b0,2'd0,16'h000},
    '{1'b0,2'd0,1'b0, 1'b1,2'd0,1'b1,16'h500, 1'b1,2'd1,16'h204},
    '{1'b0,2'd0,1'b0, 1'b0,2'd0,1'b0,16'h000, 1'b1,2'd2,16'h108},
    '{1'b0,2'd0,1'b0, 1'b0,2'd0,1'b0,16'h000, 1'b1,2'd3,16'h404},
    '{1'b1,2'd2,1'b0, 1'b1,2'd2,1'b0,16'h600, 1'b1,2'd0,16'h500},
    '{1'b0,2'd0,1'b0, 1'b0,2'd0,1'b0,16'h000, 1'b1,2'd1,16'h208},
    '{1'b0,2'd0,1'b0, 1'b0,2'd0,1'b0,16'h000, 1'b0,2'd2,16'h000},
    '{1'b0,2'd0,1'b0, 1'b0,2'd0,1'b0,16'h000, 1'b1,2'd3,16'h408},
    '{1'b1,2'd0,1'b0, 1'b0,2'd0,1'b0,16'h000, 1'b1,2'd0,16'h504},
    '{1'b0,2'd0,1'b0, 1'b0,2'd0,1'b0,16'h000, 1'b1,2'd1,16'h20C},
    '{1'b0,2'd0,1'b0, 1'b0,2'd0,1'b0,16'h000, 1'b0,2'd2,16'h000},
    '{1'b0,2'd0,1'b0, 1'b0,2'd0,1'b0,16'h000, 1'b1,2'd3,16'h40C},
    '{1'b0,2'd0,1'b0, 1'b0,2'd0,1'b0,16'h000, 1'b0,2'd0,16'h000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        blkValid = 1'b0, blkKind = 1'b0, cmpValid = 1'b0, cmpSrc = 1'b0;
  logic [1:0]  blkCtx = '0, cmpCtx = '0;
  logic [15:0] cmpPc = '0;
  logic        issueValid;
  logic [1:0]  issueCtx;
  logic [15:0] issuePc;
  int          checks = 0;
  int          failures = 0;
  int          lastSeen [NCTX];

  always #2.5 clk = ~clk;

  ctx_interleave_sched #(.CONTEXTS(NCTX), .STAGES(NSTG), .PC_W(16), .PC_STEP(4),
                         .RESET_PC(16'h100)) u_ctx_interleave_sched (
    .clk(clk), .rstN(rstN),
    .blkValid(blkValid), .blkCtx(blkCtx), .blkKind(blkKind),
    .cmpValid(cmpValid), .cmpCtx(cmpCtx), .cmpSrc(cmpSrc), .cmpPc(cmpPc),
    .issueValid(issueValid), .issueCtx(issueCtx), .issuePc(issuePc)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    failures++;
    $display("FAIL watchdog timeout");
    finishRun();
  end

  initial begin
    for (int k = 0; k < NCTX; k++) lastSeen[k] = -1;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R8: reset state before the first edge out of reset
    check(issueValid == 1'b1, "R8 valid", 32'(issueValid), 1);
    check(issueCtx == 2'd0, "R8 slot", 32'(issueCtx), 0);
    check(issuePc == 16'h100, "R8 pc", 32'(issuePc), 32'h100);

    // table walk: R1 slot order, R3/R4 bubbles, R5/R6/R7 pc values, R2 spacing
    for (int i = 0; i < NROW; i++) begin
      check(issueCtx == VECS[i].eCtx, "R1 slot", 32'(issueCtx), 32'(VECS[i].eCtx));
      check(issueValid == VECS[i].eV, "R3 R4 valid", 32'(issueValid), 32'(VECS[i].eV));
      if (VECS[i].eV)
        check(issuePc == VECS[i].ePc, "R5 R6 R7 pc", 32'(issuePc), 32'(VECS[i].ePc));
      if (issueValid) begin
        if (lastSeen[issueCtx] >= 0)
          check((i - lastSeen[issueCtx]) >= NSTG, "R2 spacing",
                32'(i - lastSeen[issueCtx]), NSTG);
        lastSeen[issueCtx] = i;
      end
      blkValid = VECS[i].blk;  blkCtx = VECS[i].bCtx;  blkKind = VECS[i].bKind;
      cmpValid = VECS[i].cmp;  cmpCtx = VECS[i].cCtx;  cmpSrc  = VECS[i].cSrc;
      cmpPc    = VECS[i].cPc;
      @(posedge clk);
      #1;
    end
    blkValid = 1'b0;
    cmpValid = 1'b0;

    // R8: mid-run reset wakes waiting contexts and restores every PC
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    for (int j = 0; j < NCTX; j++) begin
      check(issueCtx == 2'(j), "R8 slot after reset", 32'(issueCtx), 32'(j));
      check(issueValid == 1'b1, "R8 ready after reset", 32'(issueValid), 1);
      check(issuePc == 16'h100, "R8 pc after reset", 32'(issuePc), 32'h100);
      @(posedge clk);
      #1;
    end
    // R1: wrap back to context 0 after CONTEXTS-1
    check(issueCtx == 2'd0, "R1 wrap", 32'(issueCtx), 0);
    // R7: context 0 stepped once since reset
    check(issuePc == 16'h104, "R7 step after reset", 32'(issuePc), 32'h104);
    finishRun();
  end
endmodule